// File: doc/BRIEF.md
# Mode-Selectable Burst Address Sequencer

This block walks a four-beat burst through addresses that differ only in their two lowest bits. A load cycle captures a full starting address and the ordering mode. Each following advance cycle moves to the next address of the burst. The address bits above bit 1 stay as they were loaded for the whole burst.

Two orderings are offered. Linear ordering counts the low bits upward modulo 4 from the start value. Interleaved ordering forms each beat's low bits as the start bits XOR the beat index. A clock-enable input freezes all state, so the surrounding logic can insert wait states. After the fourth beat the burst wraps and repeats the same sequence. The block sits between a command decoder, which produces the load and advance strobes, and a memory array, which consumes the address.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `addr_out` is 0 and `beat` is 0.
- R2: A cycle with `ce`=1 and `load`=1 makes `addr_out` equal to that cycle's `addr_in` from the next cycle on, with `beat`=0.
- R3: Bits [AW-1:2] of `addr_out` change only through a load (`ce`=1, `load`=1).
- R4: Interleaved order (`mode_lin`=0 at load) gives low bits equal to start[1:0] XOR `beat`. Starting at 1 gives 1,0,3,2. Starting at 2 gives 2,3,0,1.
- R5: Linear order (`mode_lin`=1 at load) gives low bits equal to (start[1:0] + `beat`) mod 4. Starting at 3 gives 3,0,1,2.
- R6: A cycle with `ce`=1, `load`=0 and `advance`=1 raises `beat` by one modulo 4. Advancing past the fourth beat returns to the start address and repeats the same sequence.
- R7: A cycle with `ce`=0 leaves `addr_out` and `beat` unchanged, whatever `load`, `advance`, `mode_lin` and `addr_in` carry.
- R8: `mode_lin` is sampled only on load. Changing it during a burst leaves that burst's ordering unchanged.
- R9: `load` takes priority over `advance` in the same cycle. A cycle with `ce`=1 and neither strobe holds `addr_out` and `beat`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce | input | 1 | Clock enable; 0 freezes all state |
| load | input | 1 | Capture `addr_in` and `mode_lin`, start a burst |
| advance | input | 1 | Step to the next beat of the burst |
| mode_lin | input | 1 | Order for the burst being loaded: 1 linear, 0 interleaved |
| addr_in | input | AW | Starting address |
| addr_out | output | AW | Current burst address |
| beat | output | 2 | Beat index within the burst, 0 to 3 |

## Verification
The assertions assume only that every input is at a known 0 or 1 on each rising clock edge. They also assume that `AW` is at least 3, so the upper field is not empty. Any mix of strobes is otherwise legal, and the properties cover each combination. The stimulus changes inputs only on the falling edge and drives no unknown values. It mixes directed bursts in both orders, with `ce` gaps, simultaneous strobes and mode flips inside a burst, with a long pseudo-random run of every strobe combination.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          load,
  input  logic          advance,
  input  logic          mode_lin,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out,
  output logic [1:0]    beat
);

  logic [AW-1:0] start_q;
  logic          lin_q;
  logic [1:0]    beat_q;
  logic [1:0]    low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      lin_q   <= 1'b0;
      beat_q  <= 2'd0;
    end else if (ce) begin
      if (load) begin
        start_q <= addr_in;
        lin_q   <= mode_lin;
        beat_q  <= 2'd0;
      end else if (advance) begin
        beat_q  <= beat_q + 2'd1;
      end
    end
  end

  // Beat 0 always yields the start bits, in either order.
  assign low      = lin_q ? (start_q[1:0] + beat_q) : (start_q[1:0] ^ beat_q);
  assign addr_out = {start_q[AW-1:2], low};
  assign beat     = beat_q;

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && load) |=> (addr_out == $past(addr_in)) && (beat == 2'd0));

  assert_upper_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ce && load) |=> $stable(addr_out[AW-1:2]));

  assert_xor_invariant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !load && !lin_q) |=> ((addr_out[1:0] ^ beat) == $past(addr_out[1:0] ^ beat)));

  assert_linear_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !load && advance && lin_q) |=> (addr_out[1:0] == $past(addr_out[1:0]) + 2'd1));

  assert_beat_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !load && advance) |=> (beat == $past(beat) + 2'd1));

  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(addr_out) && $stable(beat));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !load && !advance) |=> $stable(addr_out) && $stable(beat));

endmodule

// File: tb/burst_addr_seq_tb_top.sv
`timescale 1ns/1ps
module burst_addr_seq_tb_top;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b0, load = 1'b0, advance = 1'b0, mode_lin = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic [1:0] beat;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;

  always #10 clk = ~clk;

  burst_addr_seq #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce(ce), .load(load), .advance(advance),
    .mode_lin(mode_lin), .addr_in(addr_in), .addr_out(addr_out), .beat(beat)
  );

  // Behavioural reference, written from the requirements
  longint unsigned m_start;
  int m_lin, m_beat;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_start <= 0; m_lin <= 0; m_beat <= 0;
    end else if (ce) begin
      if (load) begin
        m_start <= addr_in; m_lin <= mode_lin; m_beat <= 0;
      end else if (advance) begin
        m_beat <= (m_beat + 1) % 4;
      end
    end
  end

  function automatic longint unsigned model_addr();
    int s = int'(m_start % 4);
    int lo = m_lin ? (s + m_beat) % 4 : (s ^ m_beat);
    return (m_start / 4) * 4 + lo;
  endfunction

  task automatic chk(string tag, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk("R4/R5 model addr", addr_out, model_addr());
      chk("R6 model beat", beat, m_beat);
    end
  end

  task automatic cyc(input logic c, input logic ld, input logic adv,
                     input logic m, input logic [AW-1:0] a);
    ce = c; load = ld; advance = adv; mode_lin = m; addr_in = a;
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] held;
    int lo_il1 [4] = '{1, 0, 3, 2};
    int lo_il2 [4] = '{2, 3, 0, 1};
    int lo_ln3 [4] = '{3, 0, 1, 2};

    repeat (3) @(negedge clk);
    chk("R1 reset addr", addr_out, 0);
    chk("R1 reset beat", beat, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release addr", addr_out, 0);
    cmp_on = 1'b1;

    // Interleaved from 01
    cyc(1, 1, 0, 0, 32'hABCD_1231);
    chk("R2 load addr", addr_out, 32'hABCD_1231);
    chk("R2 load beat", beat, 0);
    for (int i = 1; i < 4; i++) begin
      cyc(1, 0, 1, 0, 32'h0);
      chk("R4 interleaved from 1", addr_out[1:0], lo_il1[i]);
      chk("R3 upper fixed", addr_out[AW-1:2], 32'hABCD_1231 >> 2);
    end
    cyc(1, 0, 1, 0, 32'h0);
    chk("R6 wrap addr", addr_out, 32'hABCD_1231);
    chk("R6 wrap beat", beat, 0);
    cyc(1, 0, 1, 0, 32'h0);
    chk("R6 repeat second beat", addr_out[1:0], 0);

    // Interleaved from 10
    cyc(1, 1, 0, 0, 32'h0000_00F6);
    for (int i = 1; i < 4; i++) begin
      cyc(1, 0, 1, 0, 32'h0);
      chk("R4 interleaved from 2", addr_out[1:0], lo_il2[i]);
    end

    // Linear from 11, mode flipped mid-burst
    cyc(1, 1, 0, 1, 32'h5555_0003);
    chk("R5 linear first", addr_out[1:0], 3);
    for (int i = 1; i < 4; i++) begin
      cyc(1, 0, 1, 0, 32'hFFFF_FFFF);
      chk("R8 mode held, linear from 3", addr_out[1:0], lo_ln3[i]);
    end

    // Clock enable low ignores everything
    cyc(1, 1, 0, 1, 32'h1234_5678);
    held = addr_out;
    cyc(0, 1, 1, 0, 32'h8765_4321);
    chk("R7 frozen addr", addr_out, held);
    chk("R7 frozen beat", beat, 0);
    cyc(0, 0, 1, 1, 32'h0);
    chk("R7 frozen on advance", beat, 0);

    // Load beats advance; idle holds
    cyc(1, 0, 1, 1, 32'h0);
    cyc(1, 1, 1, 0, 32'h0000_0A0B);
    chk("R9 load priority addr", addr_out, 32'h0000_0A0B);
    chk("R9 load priority beat", beat, 0);
    cyc(1, 0, 1, 0, 32'h0);
    held = addr_out;
    cyc(1, 0, 0, 1, 32'hDEAD_BEEF);
    chk("R9 idle hold addr", addr_out, held);
    chk("R9 idle hold beat", beat, 1);

    // Pseudo-random mix
    for (int i = 0; i < 2000; i++) begin
      int r = $urandom;
      cyc(r[0] | r[1], r[2] & r[3] & r[4], r[5] | r[6], r[7], $urandom);
    end

    cmp_on = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule